// File: doc/BRIEF.md
# Signed Conversion Result Queue

This block stores signed 13-bit results (12 bits of magnitude plus sign, two's complement) coming from a converter core, so that a host can collect them later without servicing every conversion. The converter presents one result per write strobe; up to 32 results queue up with no host action and are handed back oldest first.

The host pops a result whenever it likes through a simple read strobe. The popped value appears on the read data output one cycle after the strobe and stays there until the next successful pop. Two interrupt lines tell the host when to come back. One is level-sensitive and asserts while the number of stored results is at or above a host-programmed threshold. The other asserts while the queue is completely full. Sticky flags record a write that was lost because the queue was full and a read made while it was empty. One host clear input resets both flags.

Top module: `result_fifo`

## Requirements
- R1: Results are returned in the order they were written. A pop strobe with the queue non-empty loads the oldest stored result onto `rd_data` at the next clock edge, and `rd_data` holds that value until the next successful pop.
- R2: `count` reports the number of stored results, from 0 to 32. `empty` is high exactly when `count` is 0 and `full` is high exactly when `count` is 32. All three update at the clock edge that performs the write or pop.
- R3: A write is accepted whenever the queue is not full. A write and a pop in the same cycle while the queue is full both take effect, and `count` stays at 32.
- R4: `full_irq` is high while `full_irq_en` is 1 and the queue holds 32 results.
- R5: A write while the queue is full with no pop in the same cycle is discarded and sets the sticky `overflow` flag. The discarded value is never returned.
- R6: A pop while the queue is empty leaves `rd_data` and `count` unchanged and sets the sticky `underflow` flag.
- R7: `thr_irq` is high while `thr_irq_en` is 1, `thresh` is non-zero and `count` is greater than or equal to `thresh`. A `thresh` of 0 disables it.
- R8: `clr_flags` clears `overflow` and `underflow` at the next edge. If an event that sets a flag happens in the same cycle, that flag is set anyway.
- R9: After reset `count` is 0, `empty` is 1, `rd_data` is 0, and `overflow`, `underflow`, `thr_irq` and `full_irq` are 0.
- R10: Each 13-bit value is returned bit for bit, including the extremes 0x0FFF (+4095), 0x1000 (-4096) and 0x1FFF (-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Conversion-done write strobe |
| wr_data | input | 13 | Signed result to store |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 13 | Most recently popped result |
| thresh | input | 6 | Fill level that raises the threshold interrupt (0 disables) |
| thr_irq_en | input | 1 | Enable for the threshold interrupt |
| full_irq_en | input | 1 | Enable for the full interrupt |
| clr_flags | input | 1 | Clears the overflow and underflow flags |
| count | output | 6 | Number of stored results |
| empty | output | 1 | Queue holds no results |
| full | output | 1 | Queue holds 32 results |
| thr_irq | output | 1 | Threshold interrupt, level-sensitive |
| full_irq | output | 1 | Full interrupt, level-sensitive |
| overflow | output | 1 | Sticky flag for a discarded write |
| underflow | output | 1 | Sticky flag for a pop on an empty queue |

## Verification
The assertions assume that every input is held steady from one falling edge to the next. They also assume that `rst_n` is low for at least one rising edge before anything else happens. The bench changes inputs only on falling edges, applies each strobe for exactly one cycle and holds reset low for several cycles at the start. Within those limits it drives full-queue writes, empty-queue pops and a flag clear that coincides with a new underflow, so each property is exercised at the corner where it could fail.

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              thr_irq_en,
  input  logic              full_irq_en,
  input  logic              clr_flags,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              thr_irq,
  output logic              full_irq,
  output logic              overflow,
  output logic              underflow
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_rd, do_wr;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign do_rd    = rd_en && !empty;
  assign do_wr    = wr_en && (!full || do_rd);
  assign thr_irq  = thr_irq_en && (thresh != '0) && (count >= thresh);
  assign full_irq = full_irq_en && full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      rd_data   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && !do_wr)       overflow  <= 1'b1;
      else if (clr_flags)        overflow  <= 1'b0;
      if (rd_en && empty)        underflow <= 1'b1;
      else if (clr_flags)        underflow <= 1'b0;
    end
  end

endmodule

module result_fifo_chk #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  count,
  input logic              empty,
  input logic              full,
  input logic              full_irq,
  input logic              overflow,
  input logic              underflow,
  input logic              clr_flags
);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CNT_W'(DEPTH)) && !(full && empty)); // R2

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && !full |=> count == $past(count) + 1'b1); // R3

  AST_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |-> count == CNT_W'(DEPTH)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && !rd_en |=> overflow && count == CNT_W'(DEPTH)); // R5

  AST_UDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty |=> underflow && $stable(rd_data)); // R6

  AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags && !wr_en && !rd_en |=> !overflow && !underflow); // R8

endmodule

bind result_fifo result_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .count(count), .empty(empty), .full(full), .full_irq(full_irq),
  .overflow(overflow), .underflow(underflow), .clr_flags(clr_flags)
);

// File: tb/result_fifo_tb_top.sv
module result_fifo_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, clr_flags = 1'b0;
  logic        thr_irq_en = 1'b0, full_irq_en = 1'b0;
  logic [12:0] wr_data = '0;
  logic [5:0]  thresh = '0;
  logic [12:0] rd_data;
  logic [5:0]  count;
  logic        empty, full, thr_irq, full_irq, overflow, underflow;
  int          checks = 0, failures = 0;

  always #4 clk = ~clk;

  result_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .thresh(thresh), .thr_irq_en(thr_irq_en),
    .full_irq_en(full_irq_en), .clr_flags(clr_flags), .count(count),
    .empty(empty), .full(full), .thr_irq(thr_irq), .full_irq(full_irq),
    .overflow(overflow), .underflow(underflow)
  );

  // {wr, data, rd, expected count, expected rd_data}
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 13'h0FFF, 1'b0, 6'd1, 13'h0000},
    {1'b1, 13'h1000, 1'b0, 6'd2, 13'h0000},
    {1'b1, 13'h1FFF, 1'b1, 6'd2, 13'h0FFF},
    {1'b0, 13'h0000, 1'b1, 6'd1, 13'h1000},
    {1'b1, 13'h0001, 1'b0, 6'd2, 13'h1000},
    {1'b0, 13'h0000, 1'b1, 6'd1, 13'h1FFF},
    {1'b0, 13'h0000, 1'b1, 6'd0, 13'h0001},
    {1'b0, 13'h0000, 1'b1, 6'd0, 13'h0001}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [12:0] d, input logic r);
    wr_en = w; wr_data = d; rd_en = r;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 count", count, 0);
    chk("R9 empty", empty, 1);
    chk("R9 rd_data", rd_data, 0);
    chk("R9 flags", {overflow, underflow, thr_irq, full_irq}, 0);

    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][33], VEC[i][32:20], VEC[i][19]);
      chk("R1 R10 table count", count, VEC[i][18:13]);
      chk("R1 R10 table rd_data", rd_data, VEC[i][12:0]);
    end
    chk("R6 underflow set", underflow, 1);
    chk("R2 empty", empty, 1);

    clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
    chk("R8 clear underflow", underflow, 0);

    thresh = 6'd5; thr_irq_en = 1'b1; full_irq_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      cyc(1'b1, 13'(100 + i), 1'b0);
      if (i == 3) chk("R7 below threshold", thr_irq, 0);
      if (i == 4) chk("R7 at threshold", thr_irq, 1);
      if (i == 30) chk("R4 not yet full", {full, full_irq}, 0);
    end
    chk("R2 count full", count, 32);
    chk("R2 full", full, 1);
    chk("R4 full_irq", full_irq, 1);
    full_irq_en = 1'b0; #1;
    chk("R4 full_irq disabled", full_irq, 0);
    full_irq_en = 1'b1;

    cyc(1'b1, 13'h0AAA, 1'b0);
    chk("R5 overflow set", overflow, 1);
    chk("R5 count held", count, 32);

    cyc(1'b1, 13'h0555, 1'b1);
    chk("R3 simultaneous count", count, 32);
    chk("R3 simultaneous rd_data", rd_data, 100);

    for (int i = 1; i < 32; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R1 drain order", rd_data, 100 + i);
    end
    cyc(1'b0, '0, 1'b1);
    chk("R5 R3 last value", rd_data, 13'h0555);
    chk("R2 drained", {count, empty}, 1);

    thresh = 6'd0;
    cyc(1'b1, 13'h0123, 1'b0);
    chk("R7 zero threshold disables", thr_irq, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R10 rd_data", rd_data, 13'h0123);

    clr_flags = 1'b1;
    cyc(1'b0, '0, 1'b1);
    clr_flags = 1'b0;
    chk("R8 set wins", underflow, 1);
    chk("R8 overflow cleared", overflow, 0);
    chk("R6 rd_data held", rd_data, 13'h0123);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule